// File: doc/BRIEF.md
# Stereo auto-DMA deinterleaver

This block takes a host stream of 16-bit sample words in which the two stereo channels come packed together. Each 512-word chunk carries 256 left-channel words and then 256 right-channel words. The block separates the two halves and writes them into a left and a right region of a double-buffered input area in sound RAM. After every chunk it moves to the other half of each region, so playback can read one half while the next chunk fills the other.

Chunks are not paced by a buffer level. A sample counter advances once per output sample and asks for a new chunk at two fixed positions in its cycle. The first chunk goes out as soon as a transfer is started. When the programmed amount is used up, the block drops a status bit and pulses a completion interrupt. An acknowledge returns the transfer-mode field to automatic mode and sets the status bit again.

Top module: `adma_deint`

## Requirements
- R1: After reset, host_ready, ram_we and dma_irq are low, stat_ready is 0 and dma_mode is 2'b00.
- R2: Automatic mode is active only while adma_en is 1 and dma_mode is 2'b00. In any other setting a start pulse and sample ticks have no effect, and host_ready stays low.
- R3: A start pulse with a nonzero start_size, given while automatic mode is active, clears the sample counter, sets the write offset to 0, loads the remaining count with start_size and drops any pending completion. host_ready is high in the next cycle, because the first chunk begins at once.
- R4: During a chunk, host_ready is high and each accepted word (host_valid and host_ready) is written in the same cycle, with ram_wdata equal to host_data. Words 0 to 255 of the chunk go to LB + offset + i. Words 256 to 511 go to RB + offset + (i - 256). LB = 0x2000 + 0x400 * CORE_IDX and RB = LB + 0x200. host_ready is low outside a chunk.
- R5: The write offset is 0 for the first chunk after a start and changes between 0 and 256 after each completed chunk.
- R6: While automatic mode is active, the sample counter advances by one on each sample_tick, modulo 512. A chunk request happens when its new value is 128 or 384. A request that arrives during a chunk is ignored.
- R7: Each completed chunk takes 512 from the remaining count. If the count is then exactly 0, stat_ready goes to 0 and a completion becomes pending. The pending completion produces a one-cycle dma_irq pulse the cycle after the next sample_tick.
- R8: If a request arrives while the remaining count is 0 or negative, no chunk starts. stat_ready goes to 0 and dma_irq pulses in the next cycle.
- R9: A request that arrives while a completion is pending is ignored, even when the count is exhausted.
- R10: mode_wr loads dma_mode from mode_wdata. An irq_ack sets dma_mode to 2'b00 and stat_ready to 1 in the next cycle, and it overrides a simultaneous mode write or status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adma_en | input | 1 | Core enable for automatic transfers |
| mode_wr | input | 1 | Load strobe for the transfer-mode field |
| mode_wdata | input | 2 | New transfer-mode value |
| start | input | 1 | Start pulse for an automatic transfer |
| start_size | input | SIZE_W | Transfer amount in words |
| sample_tick | input | 1 | One pulse per output sample |
| host_data | input | 16 | Host sample word |
| host_valid | input | 1 | Host word valid |
| host_ready | output | 1 | Block accepts a word (high during a chunk) |
| ram_we | output | 1 | Sound-RAM write enable |
| ram_addr | output | ADDR_W | Sound-RAM word address |
| ram_wdata | output | 16 | Sound-RAM write data |
| irq_ack | input | 1 | Interrupt acknowledge |
| dma_irq | output | 1 | Completion interrupt pulse |
| stat_ready | output | 1 | Status flag (cleared at completion, set by acknowledge) |
| dma_mode | output | 2 | Current transfer-mode field |

## Verification
The deinterleaving and the address pattern are tried with continuous host data and with data that stalls every third cycle. Stalls move each chunk's end point relative to the sample counter, which shows whether the address index follows accepted words or clock cycles.

Three amounts are used:
- An exact multiple of 512 exercises the scheduled completion.
- A non-multiple (700) lets the remaining count go negative, so the interrupt has to come from the at-once exhaustion path.
- A single chunk paced so that a request point lands on a pending completion shows whether pending requests are really dropped.

Sample ticks every clock make requests arrive in the middle of a chunk. Disabled-mode runs show that start pulses and ticks are gated off.

// File: rtl/adma_deint_pkg.sv
package adma_deint_pkg;

    localparam int WORD_W    = 16;
    localparam int AREA_BASE = 'h2000;

    typedef enum logic [1:0] {
        MODE_AUTO = 2'b00,
        MODE_WR   = 2'b01,
        MODE_RD   = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    typedef struct packed {
        logic  pend;
        logic  stat;
        logic  irq;
        mode_e mode;
    } ctl_t;

    // Left region start for a core; each core owns four half-buffers
    function automatic int left_base(input int core, input int half);
        return AREA_BASE + core * 4 * half;
    endfunction

endpackage

// File: rtl/adma_deint_pacer.sv
module adma_deint_pacer #(
    parameter int PACE_LEN = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic trig
);
    localparam int CNT_W = $clog2(PACE_LEN);
    localparam logic [CNT_W-1:0] PT_A = CNT_W'(PACE_LEN / 4);
    localparam logic [CNT_W-1:0] PT_B = CNT_W'(3 * PACE_LEN / 4);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;

    assign nxt  = cnt + 1'b1;
    assign trig = step && (nxt == PT_A || nxt == PT_B);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= nxt;
        end
    end
endmodule

// File: rtl/adma_deint_writer.sv
module adma_deint_writer #(
    parameter int ADDR_W     = 20,
    parameter int WORD_W     = 16,
    parameter int HALF_WORDS = 256,
    parameter logic [ADDR_W-1:0] LEFT_BASE  = '0,
    parameter logic [ADDR_W-1:0] RIGHT_BASE = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          go,
    input  logic [$clog2(2*HALF_WORDS)-1:0] offset,
    input  logic [WORD_W-1:0]             host_data,
    input  logic                          host_valid,
    output logic                          busy,
    output logic                          ram_we,
    output logic [ADDR_W-1:0]             ram_addr,
    output logic [WORD_W-1:0]             ram_wdata,
    output logic                          last
);
    localparam int CHUNK = 2 * HALF_WORDS;
    localparam int IDX_W = $clog2(CHUNK);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHUNK - 1);

    logic [IDX_W-1:0] idx;
    logic             in_right;
    logic [IDX_W-2:0] pos;

    assign in_right  = idx[IDX_W-1];
    assign pos       = idx[IDX_W-2:0];
    assign ram_we    = busy && host_valid;
    assign ram_wdata = host_data;
    assign ram_addr  = (in_right ? RIGHT_BASE : LEFT_BASE)
                     + ADDR_W'(offset) + ADDR_W'(pos);
    assign last      = ram_we && (idx == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (go) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (ram_we) begin
            if (idx == IDX_LAST) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adma_deint.sv
module adma_deint
    import adma_deint_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int SIZE_W     = 20,
    parameter int HALF_WORDS = 256,
    parameter int PACE_LEN   = 512,
    parameter int CORE_IDX   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adma_en,
    input  logic              mode_wr,
    input  logic [1:0]        mode_wdata,
    input  logic              start,
    input  logic [SIZE_W-1:0] start_size,
    input  logic              sample_tick,
    input  logic [15:0]       host_data,
    input  logic              host_valid,
    output logic              host_ready,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [15:0]       ram_wdata,
    input  logic              irq_ack,
    output logic              dma_irq,
    output logic              stat_ready,
    output logic [1:0]        dma_mode
);
    localparam int CHUNK = 2 * HALF_WORDS;
    localparam int OFF_W = $clog2(CHUNK);
    localparam logic [ADDR_W-1:0] LB = ADDR_W'(left_base(CORE_IDX, HALF_WORDS));
    localparam logic [ADDR_W-1:0] RB = LB + ADDR_W'(2 * HALF_WORDS);
    localparam logic [SIZE_W:0]   CHUNK_V = (SIZE_W + 1)'(CHUNK);
    localparam logic [OFF_W-1:0]  HALF_V  = OFF_W'(HALF_WORDS);

    ctl_t             fl;
    logic [OFF_W-1:0] offset;
    logic [SIZE_W:0]  rem;       // two's complement remaining count

    logic active, start_ok, trig, busy, last, exhausted, req_ok, go;

    assign active    = adma_en && (fl.mode == MODE_AUTO);
    assign start_ok  = start && active && (|start_size);
    assign exhausted = rem[SIZE_W] || (rem == '0);
    assign req_ok    = trig && !fl.pend && !busy;
    assign go        = start_ok || (req_ok && !exhausted);

    adma_deint_pacer #(.PACE_LEN(PACE_LEN)) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_ok),
        .step (sample_tick && active),
        .trig (trig)
    );

    adma_deint_writer #(
        .ADDR_W     (ADDR_W),
        .WORD_W     (WORD_W),
        .HALF_WORDS (HALF_WORDS),
        .LEFT_BASE  (LB),
        .RIGHT_BASE (RB)
    ) u_writer (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .offset     (offset),
        .host_data  (host_data),
        .host_valid (host_valid),
        .busy       (busy),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .last       (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fl     <= '{pend: 1'b0, stat: 1'b0, irq: 1'b0, mode: MODE_AUTO};
            offset <= '0;
            rem    <= '0;
        end else begin
            if (start_ok) begin
                offset  <= '0;
                rem     <= {1'b0, start_size};
                fl.pend <= 1'b0;
                fl.irq  <= 1'b0;
            end else begin
                fl.irq <= (req_ok && exhausted) || (sample_tick && fl.pend);
                if (last) begin
                    offset <= offset ^ HALF_V;
                    rem    <= rem - CHUNK_V;
                    if (rem == CHUNK_V) begin
                        fl.pend <= 1'b1;
                        fl.stat <= 1'b0;
                    end
                end
                if (req_ok && exhausted) begin
                    fl.stat <= 1'b0;
                end
                if (sample_tick && fl.pend) begin
                    fl.pend <= 1'b0;
                end
            end
            if (mode_wr) begin
                fl.mode <= mode_e'(mode_wdata);
            end
            if (irq_ack) begin
                fl.mode <= MODE_AUTO;
                fl.stat <= 1'b1;
            end
        end
    end

    assign host_ready = busy;
    assign dma_irq    = fl.irq;
    assign stat_ready = fl.stat;
    assign dma_mode   = fl.mode;
endmodule

// File: rtl/adma_deint_chk.sv
module adma_deint_chk #(
    parameter int ADDR_W     = 20,
    parameter int SIZE_W     = 20,
    parameter int HALF_WORDS = 256,
    parameter int CORE_IDX   = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              adma_en,
    input logic              start,
    input logic [SIZE_W-1:0] start_size,
    input logic              irq_ack,
    input logic              host_ready,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              stat_ready,
    input logic [1:0]        dma_mode
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'('h2000 + CORE_IDX * 4 * HALF_WORDS);
    localparam logic [ADDR_W-1:0] HI = LO + ADDR_W'(4 * HALF_WORDS);

    AST_ACK_RESTORES: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> (stat_ready && dma_mode == 2'b00)); // R10

    AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
        (start && adma_en && dma_mode == 2'b00 && start_size != '0) |=> host_ready); // R3

    AST_GATED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!host_ready && !(adma_en && dma_mode == 2'b00)) |=> !host_ready); // R2

    AST_WRITE_REGION: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr >= LO && ram_addr < HI)); // R4
endmodule

bind adma_deint adma_deint_chk #(
    .ADDR_W     (ADDR_W),
    .SIZE_W     (SIZE_W),
    .HALF_WORDS (HALF_WORDS),
    .CORE_IDX   (CORE_IDX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .adma_en    (adma_en),
    .start      (start),
    .start_size (start_size),
    .irq_ack    (irq_ack),
    .host_ready (host_ready),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .stat_ready (stat_ready),
    .dma_mode   (dma_mode)
);

// File: tb/adma_deint_tb.sv
module adma_deint_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 20;
    localparam int SIZE_W = 20;
    localparam int WD_LIMIT = 150000;

    logic              clk = 0;
    logic              rst = 1;
    logic              adma_en = 0;
    logic              mode_wr = 0;
    logic [1:0]        mode_wdata = 0;
    logic              start = 0;
    logic [SIZE_W-1:0] start_size = 0;
    logic              sample_tick = 0;
    logic [15:0]       host_data = 0;
    logic              host_valid = 0;
    logic              irq_ack = 0;
    logic              host_ready, ram_we, dma_irq, stat_ready;
    logic [ADDR_W-1:0] ram_addr;
    logic [15:0]       ram_wdata;
    logic [1:0]        dma_mode;

    int checks = 0;
    int errors = 0;
    int cyc_n = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adma_deint u_dut (
        .clk(clk), .rst(rst), .adma_en(adma_en), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .start(start), .start_size(start_size),
        .sample_tick(sample_tick), .host_data(host_data), .host_valid(host_valid),
        .host_ready(host_ready), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .irq_ack(irq_ack), .dma_irq(dma_irq),
        .stat_ready(stat_ready), .dma_mode(dma_mode)
    );

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_off, m_rem, m_idx, m_mode;
    bit m_busy, m_pend, m_stat, m_irq;
    bit t_act, t_st, t_busy0, t_pend0, t_trg, t_irqn;
    int t_rem0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_off = 0; m_rem = 0; m_idx = 0; m_mode = 0;
            m_busy = 0; m_pend = 0; m_stat = 0; m_irq = 0;
        end else begin
            t_act = adma_en && (m_mode == 0);
            t_st = start && t_act && (start_size != 0);
            t_busy0 = m_busy; t_pend0 = m_pend; t_rem0 = m_rem;
            t_trg = 0; t_irqn = 0;
            if (t_st) begin
                m_cnt = 0; m_off = 0; m_rem = int'(start_size);
                m_pend = 0; m_busy = 1; m_idx = 0;
            end else begin
                if (sample_tick && t_act) begin
                    m_cnt = (m_cnt + 1) % 512;
                    t_trg = (m_cnt == 128) || (m_cnt == 384);
                end
                if (t_busy0 && host_valid) begin
                    if (m_idx == 511) begin
                        m_busy = 0; m_idx = 0; m_off = 256 - m_off;
                        m_rem = m_rem - 512;
                        if (m_rem == 0) begin m_pend = 1; m_stat = 0; end
                    end else m_idx++;
                end
                if (t_trg && !t_pend0 && !t_busy0) begin
                    if (t_rem0 <= 0) begin m_stat = 0; t_irqn = 1; end
                    else begin m_busy = 1; m_idx = 0; end
                end
                if (sample_tick && t_pend0) begin m_pend = 0; t_irqn = 1; end
            end
            if (mode_wr) m_mode = int'(mode_wdata);
            if (irq_ack) begin m_mode = 0; m_stat = 1; end
            m_irq = t_irqn;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    int e_addr;
    always @(negedge clk) begin
        #2;
        if (!rst && !finished) begin
            chk(host_ready == m_busy, "R6 host_ready vs pacing", host_ready, m_busy);
            chk(ram_we == (m_busy && host_valid), "R4 ram_we", ram_we, m_busy && host_valid);
            if (m_busy && host_valid) begin
                e_addr = (m_idx < 256) ? ('h2000 + m_off + m_idx)
                                       : ('h2200 + m_off + m_idx - 256);
                chk(int'(ram_addr) == e_addr, "R4 R5 ram_addr", ram_addr, e_addr);
                chk(ram_wdata == host_data, "R4 ram_wdata", ram_wdata, host_data);
            end
            chk(dma_irq == m_irq, "R7 R8 dma_irq", dma_irq, m_irq);
            chk(stat_ready == m_stat, "R8 stat_ready", stat_ready, m_stat);
            chk(int'(dma_mode) == m_mode, "R10 dma_mode", dma_mode, m_mode);
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input bit tk, input bit vld, input bit st, input bit ack, input bit mw);
        @(negedge clk);
        sample_tick = tk; host_valid = vld; start = st; irq_ack = ack; mode_wr = mw;
        host_data = host_data * 16'd5 + 16'h3c1;
    endtask

    task automatic run(input int n, input int per, input bit stall);
        for (int k = 0; k < n; k++)
            drive(per != 0 && (k % per) == per - 1, !(stall && (k % 3) == 2), 0, 0, 0);
    endtask

    task automatic do_start(input int size);
        start_size = SIZE_W'(size);
        drive(0, 1, 1, 0, 0);
    endtask

    task automatic do_ack();
        drive(0, 0, 0, 1, 0);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > WD_LIMIT && !finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc_n, WD_LIMIT);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #3;
        // R1 reset state
        chk(host_ready == 0 && ram_we == 0, "R1 ready/we after reset", {host_ready, ram_we}, 0);
        chk(dma_irq == 0 && stat_ready == 0, "R1 irq/stat after reset", {dma_irq, stat_ready}, 0);
        chk(dma_mode == 2'b00, "R1 mode after reset", dma_mode, 0);

        // R2 start while disabled is ignored
        adma_en = 0;
        do_start(1024);
        run(300, 1, 0);
        #3 chk(host_ready == 0, "R2 disabled enable gate", host_ready, 0);

        // exact multiple of 512, continuous data
        adma_en = 1;
        do_start(1024);
        drive(0, 1, 0, 0, 0);
        #3 chk(host_ready == 1, "R3 first chunk at once", host_ready, 1);
        run(1800, 4, 0);
        #3 chk(stat_ready == 0, "R7 status cleared at end", stat_ready, 0);
        do_ack();
        drive(0, 0, 0, 0, 0);
        #3 chk(stat_ready == 1 && dma_mode == 0, "R10 ack restores", {stat_ready, dma_mode}, 4);

        // R2 non-auto mode field blocks start and pacing
        mode_wdata = 2'b01;
        drive(0, 0, 0, 0, 1);
        do_start(512);
        run(600, 1, 0);
        #3 chk(host_ready == 0 && dma_mode == 2'b01, "R2 mode gate", {host_ready, dma_mode}, 1);
        mode_wdata = 2'b00;
        drive(0, 0, 0, 0, 1);

        // non-multiple amount with stalls: count goes negative
        do_start(700);
        run(2600, 4, 1);
        do_ack();

        // requests in the middle of chunks
        do_start(1024);
        run(1400, 1, 0);
        do_ack();

        // R9 request point landing on a pending completion
        do_start(512);
        run(508, 4, 0);
        run(20, 0, 0);
        #3 chk(stat_ready == 0, "R7 single chunk done", stat_ready, 0);
        do_ack();
        drive(1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        #3 chk(dma_irq == 1, "R7 pending irq on tick", dma_irq, 1);
        chk(stat_ready == 1, "R9 pending request ignored", stat_ready, 1);
        run(20, 0, 0);

        finish_run();
    end
endmodule